// File: doc/BRIEF.md
# Frequency Sweep Ramp Generator

This block generates a tuning word that changes over time for a direct digital synthesizer. It keeps a 32-bit signed step and adds it into an offset accumulator. A 16-bit timer, clocked by the synthesizer clock, sets how often these additions happen. The tuning word sent on to the phase accumulator is the base word plus the accumulated offset. A negative step makes the frequency ramp down, and a positive step makes it ramp up.

New step and timer settings wait on the input pins until an update strobe loads them into the active registers. The sweep enable selects between two modes. When sweep is off, the output is a fixed tone equal to the base word. When sweep is on, the output is the ramping sum. A clear input restarts the ramp from the base word.

Top module: `freq_sweep_ramp`

## Requirements
- R1: After reset, the offset accumulator, the timer count, the active step and the active rate are all zero. `ftwOut` equals `baseWord` and `tickOut` is low whenever `sweepEn` is low.
- R2: While `sweepEn` is low, `ftwOut` equals `baseWord` and `tickOut` stays low.
- R3: While sweeping with active rate R (R ≥ 1), `tickOut` pulses high for one cycle every R clock cycles. The first pulse comes R cycles after the timer starts from zero.
- R4: An active rate of 0 gives the same timing as a rate of 1, which is a tick on every cycle.
- R5: While sweeping, `ftwOut` equals `baseWord` plus the accumulator, modulo 2^32. Each tick adds the active step, read as two's complement, into the accumulator exactly once, at the clock edge that ends the tick cycle.
- R6: The accumulator and the output sum both wrap modulo 2^32 and never saturate.
- R7: While `clearAcc` is high, `tickOut` is low and no step is added. The edge at the end of that cycle sets both the accumulator and the timer to zero.
- R8: `deltaIn` and `rateIn` have no effect until `updateStb` is sampled high. Their values are then loaded at that edge. A tick in the same cycle as the strobe still uses the previous step.
- R9: The timer compares its count with "greater than or equal" against the active limit. If a new rate is loaded that is smaller than the current count, a tick follows in the next sweeping cycle.
- R10: Turning `sweepEn` off keeps the accumulator value and sets the timer to zero. Turning it back on resumes the ramp from the kept offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWord | input | 32 | Base tuning word from the active profile |
| deltaIn | input | 32 | Pending signed step |
| rateIn | input | 16 | Pending ramp-rate divider |
| sweepEn | input | 1 | 1 = sweep mode, 0 = single tone |
| clearAcc | input | 1 | Synchronous clear of the accumulator and the timer |
| updateStb | input | 1 | Loads the pending step and rate into the active registers |
| ftwOut | output | 32 | Tuning word sent to the phase accumulator |
| tickOut | output | 1 | Accumulation tick pulse |

## Verification
The bench runs every rate from 0 to 6 against positive, negative and extreme step values. An off-by-one divider would shift the ticks by a cycle. Treating zero as a very long count would stop the ramp. The bench also drives steps near the 32-bit limits: a design that saturates, or that extends the step as unsigned, would stop at the rail or ramp the wrong way. Other tests change the pending inputs with no strobe, shrink the rate below the running count, clear the block in a cycle where a tick is due, and pause the sweep. Each of these catches a design that loads values early, misses a tick because it compares for equality, lets a tick win over the clear, or loses the offset during a pause.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  // Strobes sent from the timer control to the accumulator datapath
  typedef struct packed {
    logic accStep;   // add the active step this cycle
    logic accClr;    // zero the accumulator this cycle
  } ctrlStrobes_t;

  // Terminal count for a given rate; a rate of zero behaves like one
  function automatic logic [15:0] rateLimit(input logic [15:0] rate);
    return (rate == 16'd0) ? 16'd0 : rate - 16'd1;
  endfunction

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              updateStb,
  input  logic              sweepEn,
  input  logic              clearAcc,
  output ctrlStrobes_t      strobes,
  output logic              tickNow
);

  logic [RATE_W-1:0] rateAct;
  logic [RATE_W-1:0] tmrCnt;
  logic [RATE_W-1:0] tmrLimit;

  always_comb begin
    tmrLimit = (rateAct == '0) ? '0 : rateAct - 1'b1;
  end

  // greater-or-equal so that a shrunken rate still ticks promptly
  always_comb begin
    tickNow = sweepEn && !clearAcc && (tmrCnt >= tmrLimit);
    strobes.accStep = tickNow;
    strobes.accClr  = clearAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateAct <= '0;
      tmrCnt  <= '0;
    end else begin
      if (updateStb) rateAct <= rateIn;
      if (clearAcc || !sweepEn || tickNow) tmrCnt <= '0;
      else                                 tmrCnt <= tmrCnt + 1'b1;
    end
  end

  // R7
  clear_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearAcc |=> (tmrCnt == '0));

  // R2
  idle_notick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sweepEn |-> !strobes.accStep);

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accStep |=> (tmrCnt == '0));

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |=> $stable(rateAct));

endmodule

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import sweep_pkg::*;
#(
  parameter int FTW_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FTW_W-1:0] baseWord,
  input  logic [FTW_W-1:0] deltaIn,
  input  logic             updateStb,
  input  logic             sweepEn,
  input  ctrlStrobes_t     strobes,
  output logic [FTW_W-1:0] ftwOut
);

  logic [FTW_W-1:0] deltaAct;
  logic [FTW_W-1:0] accVal;

  // two's-complement add: a modular sum serves signed and unsigned alike
  always_ff @(posedge clk) begin
    if (!rstN) begin
      deltaAct <= '0;
      accVal   <= '0;
    end else begin
      if (updateStb) deltaAct <= deltaIn;
      if (strobes.accClr)       accVal <= '0;
      else if (strobes.accStep) accVal <= accVal + deltaAct;
    end
  end

  always_comb begin
    ftwOut = sweepEn ? (baseWord + accVal) : baseWord;
  end

  // R5
  acc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accStep && !strobes.accClr) |=> (accVal == $past(accVal) + $past(deltaAct)));

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accClr |=> (accVal == '0));

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accStep && !strobes.accClr) |=> $stable(accVal));

  // R8
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |=> $stable(deltaAct));

endmodule

// File: rtl/freq_sweep_ramp.sv
module freq_sweep_ramp
  import sweep_pkg::*;
#(
  parameter int FTW_W  = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FTW_W-1:0]  baseWord,
  input  logic [FTW_W-1:0]  deltaIn,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              sweepEn,
  input  logic              clearAcc,
  input  logic              updateStb,
  output logic [FTW_W-1:0]  ftwOut,
  output logic              tickOut
);

  ctrlStrobes_t strobes;
  logic         tickNow;

  sweep_ctrl #(.RATE_W(RATE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rateIn(rateIn), .updateStb(updateStb),
    .sweepEn(sweepEn), .clearAcc(clearAcc), .strobes(strobes), .tickNow(tickNow)
  );

  sweep_dpath #(.FTW_W(FTW_W)) dpath_i (
    .clk(clk), .rstN(rstN), .baseWord(baseWord), .deltaIn(deltaIn),
    .updateStb(updateStb), .sweepEn(sweepEn), .strobes(strobes), .ftwOut(ftwOut)
  );

  assign tickOut = tickNow;

  // R2
  tone_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sweepEn |-> (ftwOut == baseWord && !tickOut));

endmodule

// File: tb/freq_sweep_ramp_tb.sv
module freq_sweep_ramp_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] baseWord, deltaIn;
  logic [15:0] rateIn;
  logic        sweepEn, clearAcc, updateStb;
  logic [31:0] ftwOut;
  logic        tickOut;

  int nVec = 0;
  int nBad = 0;
  int cyc  = 0;

  // reference state computed from the requirements
  logic [31:0] mAcc, mDelta;
  logic [15:0] mRate, mCnt;

  always #10 clk = ~clk;

  freq_sweep_ramp dut_i (
    .clk(clk), .rstN(rstN), .baseWord(baseWord), .deltaIn(deltaIn),
    .rateIn(rateIn), .sweepEn(sweepEn), .clearAcc(clearAcc),
    .updateStb(updateStb), .ftwOut(ftwOut), .tickOut(tickOut)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, advance model after it
  task automatic step(input string tag, input logic en, input logic clr,
                      input logic upd, input logic [31:0] dIn, input logic [15:0] rIn);
    logic [15:0] lim;
    logic        eTick;
    @(negedge clk);
    sweepEn = en; clearAcc = clr; updateStb = upd; deltaIn = dIn; rateIn = rIn;
    #2;
    lim   = (mRate == 16'd0) ? 16'd0 : mRate - 16'd1;
    eTick = en && !clr && (mCnt >= lim);
    chk32({tag, " tick"}, {31'd0, tickOut}, {31'd0, eTick});
    chk32({tag, " ftw"}, ftwOut, en ? baseWord + mAcc : baseWord);
    @(posedge clk);
    #1;
    if (clr)        mAcc = 32'd0;
    else if (eTick) mAcc = mAcc + mDelta;
    if (clr || !en || eTick) mCnt = 16'd0;
    else                     mCnt = mCnt + 16'd1;
    if (upd) begin mDelta = dIn; mRate = rIn; end
  endtask

  initial begin
    logic [31:0] deltas [4];
    deltas[0] = 32'd5; deltas[1] = 32'hFFFF_FFFD;
    deltas[2] = 32'h7FFF_FFFF; deltas[3] = 32'h8000_0001;
    rstN = 1'b0; baseWord = 32'h1000_0000; deltaIn = 32'd0; rateIn = 16'd0;
    sweepEn = 1'b0; clearAcc = 1'b0; updateStb = 1'b0;
    mAcc = 0; mDelta = 0; mRate = 0; mCnt = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state, tone output then zero-step sweep
    step("R1 idle", 1'b0, 1'b0, 1'b0, 32'd7, 16'd3);
    step("R1 sweep", 1'b1, 1'b0, 1'b0, 32'd7, 16'd3);
    step("R1 sweep", 1'b1, 1'b0, 1'b0, 32'd7, 16'd3);

    // R3 R4 R5: all small rates against signed and extreme steps
    for (int r = 0; r <= 6; r++) begin
      for (int d = 0; d < 4; d++) begin
        step("R8 load", 1'b1, 1'b1, 1'b1, deltas[d], 16'(r));
        for (int k = 0; k < 3 * (r + 1) + 2; k++)
          step(r == 0 ? "R4 rate0" : "R3 R5 ramp", 1'b1, 1'b0, 1'b0, deltas[d], 16'(r));
      end
    end

    // R6: wrap through zero with no saturation
    baseWord = 32'hFFFF_FFF0;
    step("R6 load", 1'b1, 1'b1, 1'b1, 32'h0000_0020, 16'd1);
    for (int k = 0; k < 6; k++) step("R6 wrap", 1'b1, 1'b0, 1'b0, 32'h0000_0020, 16'd1);

    // R8: pending inputs change with no strobe
    for (int k = 0; k < 8; k++)
      step("R8 nostrobe", 1'b1, 1'b0, 1'b0, 32'h0BAD_0000 + k, 16'(k + 9));
    // R8: strobe in a tick cycle uses the old step
    step("R8 strobe", 1'b1, 1'b0, 1'b1, 32'd100, 16'd2);
    for (int k = 0; k < 5; k++) step("R8 after", 1'b1, 1'b0, 1'b0, 32'd1, 16'd9);

    // R7: clear while a tick is due
    step("R7 clear", 1'b1, 1'b1, 1'b1, 32'd3, 16'd1);
    step("R7 after", 1'b1, 1'b0, 1'b0, 32'd3, 16'd1);
    step("R7 clrtick", 1'b1, 1'b1, 1'b0, 32'd3, 16'd1);
    step("R7 after", 1'b1, 1'b0, 1'b0, 32'd3, 16'd1);

    // R9: shrink the rate below the running count
    step("R9 load", 1'b1, 1'b1, 1'b1, 32'd11, 16'd10);
    for (int k = 0; k < 7; k++) step("R9 run", 1'b1, 1'b0, 1'b0, 32'd11, 16'd10);
    step("R9 shrink", 1'b1, 1'b0, 1'b1, 32'd11, 16'd3);
    for (int k = 0; k < 8; k++) step("R9 tick", 1'b1, 1'b0, 1'b0, 32'd11, 16'd3);

    // R2 R10: pause keeps offset, resume continues
    baseWord = 32'h2222_0000;
    for (int k = 0; k < 5; k++) step("R2 R10 pause", 1'b0, 1'b0, 1'b0, 32'd11, 16'd3);
    for (int k = 0; k < 8; k++) step("R10 resume", 1'b1, 1'b0, 1'b0, 32'd11, 16'd3);
    step("R2 clearidle", 1'b0, 1'b1, 1'b0, 32'd11, 16'd3);
    step("R10 zeroed", 1'b1, 1'b0, 1'b0, 32'd11, 16'd3);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule